// File: doc/BRIEF.md
# Bus Initiator Burst Termination Controller

This block is the initiator-side control path that ends a burst which a bridge has started on a parallel, PCI-style shared bus. After a start request in idle it opens the address phase by driving the frame strobe low, then drives the initiator-ready strobe low and waits for a target to claim the cycle with the device-select strobe. If no target claims the cycle within a fixed window, the burst is closed by master abort and a sticky status bit records the event. That bit stays set until software writes a one to clear it.

Once a target has claimed the burst, the controller watches four independent reasons to stop. These are: the next data phase would leave the current 4 KB page; the local posted-write store is full; the store is about to send its final word; or the latency timer has run out while the bus grant has been removed. Any one of them raises the frame strobe, which marks the final data phase. The ready strobe then stays low until the target completes that phase, and the bus is idle on the following clock. A single-cycle completion pulse tells the caller whether the burst ended normally or by abort. All bus strobes are active low. The write store is seen only through two flags.

Top module: `burst_term_ctrl`

## Requirements
- R1: After reset, frame_n and irdy_n are 1, and done and rma_status are 0.
- R2: When start is 1 in idle, the next cycle (cycle 1) has frame_n=0 with irdy_n=1. From cycle 2, irdy_n=0. A start seen outside idle is ignored.
- R3: If devsel_n is 1 in each of cycles 1 to 5 (DSEL_WAIT=5), cycle 6 has frame_n=1 and irdy_n=0. Cycle 7 is idle, with done=1 and done_abort=1.
- R4: If devsel_n is 0 in any cycle from 1 to 5, including cycle 5, no abort takes place and frame_n stays 0 in cycle 6.
- R5: An abort sets rma_status, and rma_status stays 1. A cycle with clr_wr=1 and clr_bit=1 clears it. clr_wr with clr_bit=0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R6: In a claimed data cycle, if the offset of cur_addr within its 4096-byte page is 4096-STEP_BYTES or more (STEP_BYTES=4, so offset 0xFFC or more), the next cycle has frame_n=1 and irdy_n=0.
- R7: In a claimed data cycle, wbuf_full=1 ends the burst in the same way.
- R8: In a claimed data cycle, wbuf_last=1 ends the burst in the same way.
- R9: In a claimed data cycle, an expired latency timer together with gnt_n=1 ends the burst in the same way. An expired timer while gnt_n=0 does not end the burst.
- R10: After frame_n rises, irdy_n stays 0 until a cycle with trdy_n=0. The next cycle is idle, with done=1 and done_abort=0.
- R11: Before devsel_n has been seen low, the four stop conditions have no effect and frame_n stays 0.
- R12: done is high for exactly one cycle per burst.
- R13: The latency timer loads lat_init on the edge that asserts the frame strobe (value lat_init in cycle 1). It then falls by one per clock while frame_n=0 and counts as expired at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a burst (taken in idle only) |
| lat_init | input | LAT_W | Latency timer start value |
| gnt_n | input | 1 | Bus grant, active low |
| devsel_n | input | 1 | Target claim strobe, active low |
| trdy_n | input | 1 | Target ready strobe, active low |
| cur_addr | input | ADDR_W | Byte address of the data phase after the one on the bus |
| wbuf_full | input | 1 | Posted-write store is full |
| wbuf_last | input | 1 | Store is about to send its final word |
| clr_wr | input | 1 | Status write strobe |
| clr_bit | input | 1 | Write data for the abort status bit (1 clears) |
| frame_n | output | 1 | Frame strobe, active low |
| irdy_n | output | 1 | Initiator ready strobe, active low |
| done | output | 1 | One-cycle burst completion pulse |
| done_abort | output | 1 | Burst ended by master abort (valid with done) |
| rma_status | output | 1 | Sticky received-master-abort bit |

## Verification
Two functions of this block can act on the same edge: the abort path setting rma_status, and a write-one-to-clear aimed at the same bit. The bench provokes this by starting a burst that no target claims and holding clr_wr and clr_bit high during the turnaround cycle, where frame_n is already high and irdy_n is still low. The edge that ends that cycle both sets and clears the bit. The bench then expects rma_status to be 1, and expects a later clear on its own to bring it to 0.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_LAST,
    ST_ABT
  } btc_state_e;

  // True when a phase at addr plus step bytes would leave the page.
  function automatic logic page_tail(input logic [31:0] addr,
                                     input int unsigned page_bits,
                                     input int unsigned step);
    logic [31:0] mask;
    mask = (32'd1 << page_bits) - 32'd1;
    return ((addr & mask) + step) > mask;
  endfunction

  // Saturating decrement for the latency timer.
  function automatic logic [7:0] sat_dec(input logic [7:0] v);
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

endpackage

// File: rtl/btc_lat_timer.sv
module btc_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [LAT_W-1:0] init,
  output logic             expired
);
  import btc_pkg::*;

  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= init;
    else if (run)  cnt_q <= LAT_W'(sat_dec(8'(cnt_q)));
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/btc_dsel_watch.sv
module btc_dsel_watch #(
  parameter int DSEL_WAIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic window,
  input  logic devsel_n,
  output logic claim_now,
  output logic expire
);
  localparam int CW = $clog2(DSEL_WAIT + 1) + 1;

  logic [CW-1:0] cnt_q;
  logic          claimed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      claimed_q <= 1'b0;
    end else if (load) begin
      cnt_q     <= CW'(1);
      claimed_q <= 1'b0;
    end else if (window) begin
      if (cnt_q < CW'(DSEL_WAIT)) cnt_q <= cnt_q + CW'(1);
      if (!devsel_n)              claimed_q <= 1'b1;
    end
  end

  assign claim_now = claimed_q | ~devsel_n;
  assign expire    = window & ~claim_now & (cnt_q == CW'(DSEL_WAIT));
endmodule

// File: rtl/btc_stop_decode.sv
module btc_stop_decode #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int STEP_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              wbuf_full,
  input  logic              wbuf_last,
  input  logic              lat_expired,
  input  logic              gnt_n,
  output logic              stop_req
);
  import btc_pkg::*;

  logic at_page_end;
  logic lat_out;

  assign at_page_end = page_tail(32'(cur_addr), PAGE_BITS, STEP_BYTES);
  assign lat_out     = lat_expired & gnt_n;
  assign stop_req    = at_page_end | wbuf_full | wbuf_last | lat_out;
endmodule

// File: rtl/burst_term_ctrl.sv
module burst_term_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LAT_W      = 8,
  parameter int PAGE_BITS  = 12,
  parameter int STEP_BYTES = 4,
  parameter int DSEL_WAIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LAT_W-1:0]  lat_init,
  input  logic              gnt_n,
  input  logic              devsel_n,
  input  logic              trdy_n,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              wbuf_full,
  input  logic              wbuf_last,
  input  logic              clr_wr,
  input  logic              clr_bit,
  output logic              frame_n,
  output logic              irdy_n,
  output logic              done,
  output logic              done_abort,
  output logic              rma_status
);
  import btc_pkg::*;

  btc_state_e state_q, state_d;

  // Named internal events.
  logic launch;
  logic window;
  logic claim_now;
  logic abort_fire;
  logic stop_req;
  logic stop_fire;
  logic lat_expired;
  logic final_ok;

  assign launch    = (state_q == ST_IDLE) & start;
  assign window    = (state_q == ST_ADDR) | (state_q == ST_DATA);
  assign stop_fire = (state_q == ST_DATA) & claim_now & stop_req & ~abort_fire;
  assign final_ok  = (state_q == ST_LAST) & ~trdy_n;

  btc_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (launch),
    .run     (window),
    .init    (lat_init),
    .expired (lat_expired)
  );

  btc_dsel_watch #(.DSEL_WAIT(DSEL_WAIT)) u_dsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .window    (window),
    .devsel_n  (devsel_n),
    .claim_now (claim_now),
    .expire    (abort_fire)
  );

  btc_stop_decode #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .STEP_BYTES (STEP_BYTES)
  ) u_stop (
    .cur_addr    (cur_addr),
    .wbuf_full   (wbuf_full),
    .wbuf_last   (wbuf_last),
    .lat_expired (lat_expired),
    .gnt_n       (gnt_n),
    .stop_req    (stop_req)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_ADDR;
      ST_ADDR: state_d = abort_fire ? ST_ABT : ST_DATA;
      ST_DATA: begin
        if (abort_fire)     state_d = ST_ABT;
        else if (stop_fire) state_d = ST_LAST;
      end
      ST_LAST: if (!trdy_n) state_d = ST_IDLE;
      ST_ABT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      done       <= 1'b0;
      done_abort <= 1'b0;
      rma_status <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= final_ok | (state_q == ST_ABT);
      if (final_ok | (state_q == ST_ABT)) done_abort <= (state_q == ST_ABT);
      // Set has priority over a same-edge write-one-to-clear.
      if (state_q == ST_ABT)     rma_status <= 1'b1;
      else if (clr_wr & clr_bit) rma_status <= 1'b0;
    end
  end

  assign frame_n = ~window;
  assign irdy_n  = ~((state_q == ST_DATA) | (state_q == ST_LAST) | (state_q == ST_ABT));
endmodule

// File: rtl/btc_checker.sv
module btc_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic clr_wr,
  input logic clr_bit,
  input logic frame_n,
  input logic irdy_n,
  input logic done,
  input logic done_abort,
  input logic rma_status,
  input logic abort_fire,
  input logic stop_fire,
  input logic claim_now
);
  assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && irdy_n && start) |=> (!frame_n && irdy_n));

  assert_abort_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> (frame_n && !irdy_n));

  assert_abort_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> ##1 (done && done_abort));

  assert_rma_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rma_status && !(clr_wr && clr_bit)) |=> rma_status);

  assert_stop_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fire |=> (frame_n && !irdy_n));

  assert_frame_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irdy_n) |-> (frame_n && $past(frame_n)));

  assert_unclaimed_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !irdy_n && !claim_now && !abort_fire) |=> !frame_n);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind burst_term_ctrl btc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .clr_wr     (clr_wr),
  .clr_bit    (clr_bit),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .done       (done),
  .done_abort (done_abort),
  .rma_status (rma_status),
  .abort_fire (abort_fire),
  .stop_fire  (stop_fire),
  .claim_now  (claim_now)
);

// File: tb/burst_term_ctrl_bench.sv
`timescale 1ns/1ps
module burst_term_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  lat_init = 8'd40;
  logic        gnt_n = 1'b0;
  logic        devsel_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic [31:0] cur_addr = 32'd0;
  logic        wbuf_full = 1'b0;
  logic        wbuf_last = 1'b0;
  logic        clr_wr = 1'b0;
  logic        clr_bit = 1'b0;
  logic        frame_n, irdy_n, done, done_abort, rma_status;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_term_ctrl u_burst_term_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lat_init(lat_init),
    .gnt_n(gnt_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .cur_addr(cur_addr), .wbuf_full(wbuf_full), .wbuf_last(wbuf_last),
    .clr_wr(clr_wr), .clr_bit(clr_bit), .frame_n(frame_n), .irdy_n(irdy_n),
    .done(done), .done_abort(done_abort), .rma_status(rma_status)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    devsel_n = 1'b1; trdy_n = 1'b1; gnt_n = 1'b0;
    wbuf_full = 1'b0; wbuf_last = 1'b0; cur_addr = 32'd0;
    clr_wr = 1'b0; clr_bit = 1'b0;
  endtask

  // Leaves the bench observing cycle 1 (address phase).
  task automatic launch(input logic [7:0] lat);
    lat_init = lat; start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "frame_n", frame_n, 1);
    chk("R1", "irdy_n", irdy_n, 1);
    chk("R1", "done", done, 0);
    chk("R1", "rma_status", rma_status, 0);
  endtask

  task automatic t_abort();
    launch(8'd40);
    chk("R2", "c1 frame_n", frame_n, 0);
    chk("R2", "c1 irdy_n", irdy_n, 1);
    start = 1'b1;                       // ignored while busy
    cyc();
    start = 1'b0;
    chk("R2", "c2 irdy_n", irdy_n, 0);
    cyc(); cyc(); cyc();
    chk("R3", "c5 frame_n", frame_n, 0);
    cyc();
    chk("R3", "c6 frame_n", frame_n, 1);
    chk("R3", "c6 irdy_n", irdy_n, 0);
    cyc();
    chk("R3", "c7 irdy_n", irdy_n, 1);
    chk("R3", "c7 done", done, 1);
    chk("R3", "c7 done_abort", done_abort, 1);
    chk("R5", "rma set", rma_status, 1);
    cyc();
    chk("R12", "done drop", done, 0);
    chk("R2", "busy start ignored", frame_n, 1);
    chk("R5", "rma sticky", rma_status, 1);
  endtask

  task automatic t_clear();
    clr_wr = 1'b1; clr_bit = 1'b0;
    cyc();
    clr_wr = 1'b0;
    chk("R5", "clr_bit=0 no effect", rma_status, 1);
    clr_wr = 1'b1; clr_bit = 1'b1;
    cyc();
    clr_wr = 1'b0; clr_bit = 1'b0;
    chk("R5", "w1c clears", rma_status, 0);
  endtask

  task automatic t_late_claim();
    launch(8'd40);
    cyc(); cyc(); cyc(); cyc();         // observing cycle 5
    devsel_n = 1'b0;
    cyc();
    chk("R4", "c6 frame_n", frame_n, 0);
    wbuf_last = 1'b1;
    cyc();
    wbuf_last = 1'b0;
    chk("R8", "c7 frame_n", frame_n, 1);
    chk("R8", "c7 irdy_n", irdy_n, 0);
    cyc();
    chk("R10", "waits for trdy", irdy_n, 0);
    trdy_n = 1'b0;
    cyc();
    chk("R10", "idle irdy_n", irdy_n, 1);
    chk("R10", "done", done, 1);
    chk("R10", "done_abort", done_abort, 0);
    chk("R4", "no rma", rma_status, 0);
    quiet();
    cyc();
  endtask

  task automatic t_page();
    launch(8'd40);
    devsel_n = 1'b0; trdy_n = 1'b0; cur_addr = 32'h1234_0FF8;
    cyc();
    chk("R6", "offset FF8 continues", frame_n, 0);
    cur_addr = 32'h1234_0FFC;
    cyc();
    chk("R6", "offset FFC frame_n", frame_n, 1);
    chk("R6", "offset FFC irdy_n", irdy_n, 0);
    cur_addr = 32'd0;
    cyc();
    chk("R10", "page end done", done, 1);
    quiet();
    cyc();
  endtask

  task automatic t_full();
    launch(8'd40);
    wbuf_full = 1'b1;
    cyc(); cyc();
    chk("R11", "full before claim ignored", frame_n, 0);
    devsel_n = 1'b0;
    cyc();
    chk("R7", "full ends burst", frame_n, 1);
    chk("R7", "full irdy_n", irdy_n, 0);
    wbuf_full = 1'b0; trdy_n = 1'b0;
    cyc();
    chk("R10", "full done", done, 1);
    quiet();
    cyc();
  endtask

  task automatic t_lat();
    gnt_n = 1'b1;
    launch(8'd3);
    devsel_n = 1'b0;
    cyc(); cyc();
    chk("R13", "timer 1 running", frame_n, 0);
    cyc();
    chk("R13", "timer 0 this cycle", frame_n, 0);
    cyc();
    chk("R9", "expired+gnt off", frame_n, 1);
    trdy_n = 1'b0;
    cyc();
    quiet();
    cyc();
    launch(8'd2);
    devsel_n = 1'b0;
    cyc(); cyc(); cyc(); cyc();
    chk("R9", "expired gnt held", frame_n, 0);
    gnt_n = 1'b1;
    cyc();
    chk("R9", "grant removed", frame_n, 1);
    trdy_n = 1'b0;
    cyc();
    chk("R10", "lat done", done, 1);
    quiet();
    cyc();
  endtask

  task automatic t_set_vs_clear();
    launch(8'd40);
    cyc(); cyc(); cyc(); cyc(); cyc();  // cycle 6: abort turnaround
    clr_wr = 1'b1; clr_bit = 1'b1;
    cyc();
    clr_wr = 1'b0; clr_bit = 1'b0;
    chk("R5", "set wins over clear", rma_status, 1);
    clr_wr = 1'b1; clr_bit = 1'b1;
    cyc();
    quiet();
    chk("R5", "later clear", rma_status, 0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_abort();
    t_clear();
    t_late_claim();
    t_page();
    t_full();
    t_lat();
    t_set_vs_clear();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule